// File: doc/BRIEF.md
# DDR Read Burst Truncation Tracker

This block sits on the controller side of a double-data-rate SDRAM port and follows the command stream the controller sends. For every half-clock data slot it predicts three things: whether read data will be on the bus, which READ produced the beat, and the beat's column position inside the burst. Two data beats move per clock, one on the rising edge and one on the falling edge, so the block has two output slots per clock.

Bursts are shortened while they run. A later READ to any bank takes the data slots over from the point where its own data begins. A PRECHARGE to the bank of the burst in flight stops the data a CAS latency after the PRECHARGE. The gap between READ and PRECHARGE therefore sets how many beats arrive. Latency is tracked in half-clock steps, so a CAS latency of 2 or 2.5 clocks uses one shared datapath.

The command decoder also sets a sticky protocol-error flag. This happens for the reserved command code, and for any READ or PRECHARGE that comes less than `GAP_MIN` clocks after an accepted READ. With the default `GAP_MIN` of 1, commands one clock apart are legal. A rejected command has no other effect. A data-return unit can use the predicted slots to capture and route read data.

Top module: `ddr_rd_trunc_tracker`

## Requirements
- R1: During reset and afterwards, until a READ's data arrives, both slots report not valid and the error flag is low.
- R2: With `cfg_cl_half`=0 (CAS latency 2), a READ sampled at clock edge c yields beat 0 in the rising slot and beat 1 in the falling slot in the cycle after edge c+2. Each following pair of beats appears one cycle later.
- R3: With `cfg_cl_half`=1 (CAS latency 2.5), a READ sampled at edge c yields beat 0 in the falling slot after edge c+2. Beats 1 and 2 then occupy the rising and falling slots after edge c+3, and so on.
- R4: `cfg_bl` selects the burst length: 0 gives 2, 1 gives 4, and 2 or 3 gives 8. An uninterrupted burst delivers exactly that many valid beats, back to back.
- R5: Beat index n of a READ with column bits `rd_col` is reported as `(rd_col & ~M) | ((rd_col + n) & M)`, where M is the burst length minus one. The index therefore wraps inside the aligned block.
- R6: Each accepted READ gets a 4-bit tag. The first READ after reset gets tag 0, and each later READ gets the next value, wrapping modulo 16. Every valid beat carries its READ's tag.
- R7: A READ sampled at edge c2 while an earlier burst is still producing data ends that burst. This applies whatever bank either READ targets. No beat of the old burst appears from the new burst's beat 0 onward.
- R8: A PRECHARGE sampled at edge p to the bank of the most recent READ removes every beat of that READ that would fall a CAS latency or more after p. A READ at c followed by such a PRECHARGE at c+d delivers min(2d, burst length) beats.
- R9: A PRECHARGE to any other bank, or one issued when no burst is in flight, changes no output.
- R10: Command encoding is 0 NOP, 1 READ, 2 PRECHARGE, 3 reserved. A reserved command raises the error flag one edge later and otherwise acts like a NOP.
- R11: Once raised, the error flag stays high until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Command clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd | input | 2 | Command code: 0 NOP, 1 READ, 2 PRECHARGE, 3 reserved |
| bank | input | 2 | Bank address of the command |
| rd_col | input | 3 | Low column bits of a READ, which give the burst start position |
| cfg_bl | input | 2 | Burst length select (static) |
| cfg_cl_half | input | 1 | 0: CAS latency 2, 1: CAS latency 2.5 (static) |
| rise_vld | output | 1 | Rising-edge beat is valid |
| rise_tag | output | TAG_W | Tag of the rising-edge beat |
| rise_idx | output | 3 | Column index of the rising-edge beat |
| fall_vld | output | 1 | Falling-edge beat is valid |
| fall_tag | output | TAG_W | Tag of the falling-edge beat |
| fall_idx | output | 3 | Column index of the falling-edge beat |
| proto_err | output | 1 | Sticky protocol-error flag |

## Verification
Some properties are checked on every cycle:
- the slots stay quiet in the first cycles after reset;
- the error flag stays set, and rises after a reserved code;
- two valid slots in the same cycle with the same tag carry wrapped, consecutive column indices;
- a change of tag between those two slots is always a step of one.

Other behaviour depends on the exact cycle in which beats start and stop, so only the bench's scenarios can show it. That covers the CAS-latency placement of beat 0 on the correct edge, burst lengths, cut-off by a later READ, truncation by a same-bank PRECHARGE, and the lack of effect of a PRECHARGE to another bank. These scenarios run for every burst length code and both latencies.

// File: rtl/ddr_rd_trunc_tracker.sv
module ddr_rd_trunc_tracker #(
  parameter int TAG_W   = 4,
  parameter int GAP_MIN = 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [1:0]       cmd,
  input  logic [1:0]       bank,
  input  logic [2:0]       rd_col,
  input  logic [1:0]       cfg_bl,
  input  logic             cfg_cl_half,
  output logic             rise_vld,
  output logic [TAG_W-1:0] rise_tag,
  output logic [2:0]       rise_idx,
  output logic             fall_vld,
  output logic [TAG_W-1:0] fall_tag,
  output logic [2:0]       fall_idx,
  output logic             proto_err
);

  localparam int IW = 3;
  localparam int EW = 1 + TAG_W + IW;
  localparam int PD = 7;
  localparam int GW = $clog2(GAP_MIN + 1) + 1;

  logic [2:0]       mask;
  logic [3:0]       bl_n;
  logic             act;
  logic [1:0]       cur_bank;
  logic [TAG_W-1:0] cur_tag, tag_ctr;
  logic [2:0]       base, off;
  logic [3:0]       cnt;
  logic [GW-1:0]    since_rd;
  logic [EW-1:0]    pipe [PD];

  assign mask = (cfg_bl == 2'd0) ? 3'd1 : (cfg_bl == 2'd1) ? 3'd3 : 3'd7;
  assign bl_n = {1'b0, mask} + 4'd1;

  wire too_soon = since_rd < GW'(GAP_MIN);
  wire is_rd    = cmd == 2'd1;
  wire is_pre   = cmd == 2'd2;
  wire bad      = (cmd == 2'd3) | ((is_rd | is_pre) & too_soon);
  wire rd_ok    = is_rd & ~too_soon;
  wire kill     = is_pre & ~too_soon & act & (bank == cur_bank);

  logic             c_live;
  logic [TAG_W-1:0] c_tag;
  logic [2:0]       c_base, c_off;
  logic [3:0]       c_n;

  always_comb begin
    if (rd_ok) begin
      c_live = 1'b1;
      c_tag  = tag_ctr;
      c_base = rd_col & ~mask;
      c_off  = rd_col & mask;
      c_n    = 4'd0;
    end else begin
      c_live = act & ~kill;
      c_tag  = cur_tag;
      c_base = base;
      c_off  = off;
      c_n    = cnt;
    end
  end

  wire [2:0] i0 = c_base | (3'(c_off + c_n[2:0]) & mask);
  wire [2:0] i1 = c_base | (3'(c_off + c_n[2:0] + 3'd1) & mask);
  wire [EW-1:0] h0 = {c_live, c_tag, i0};
  wire [EW-1:0] h1 = {c_live, c_tag, i1};
  wire [3:0] n_next = 4'(c_n + 4'd2);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      act       <= 1'b0;
      cur_bank  <= '0;
      cur_tag   <= '0;
      tag_ctr   <= '0;
      base      <= '0;
      off       <= '0;
      cnt       <= '0;
      since_rd  <= GW'(GAP_MIN);
      proto_err <= 1'b0;
      for (int j = 0; j < PD; j++) pipe[j] <= '0;
    end else begin
      act <= c_live & (n_next < bl_n);
      cnt <= n_next;
      if (rd_ok) begin
        cur_bank <= bank;
        cur_tag  <= tag_ctr;
        tag_ctr  <= tag_ctr + 1'b1;
        base     <= c_base;
        off      <= c_off;
        since_rd <= GW'(1);
      end else if (too_soon) begin
        since_rd <= since_rd + GW'(1);
      end
      if (bad) proto_err <= 1'b1;
      pipe[0] <= h1;
      pipe[1] <= h0;
      for (int j = 2; j < PD; j++) pipe[j] <= pipe[j-2];
    end
  end

  wire [EW-1:0] rise_e = cfg_cl_half ? pipe[6] : pipe[5];
  wire [EW-1:0] fall_e = cfg_cl_half ? pipe[5] : pipe[4];

  assign {rise_vld, rise_tag, rise_idx} = rise_e;
  assign {fall_vld, fall_tag, fall_idx} = fall_e;

endmodule

// File: rtl/ddr_rd_trunc_tracker_chk.sv
module ddr_rd_trunc_tracker_chk #(
  parameter int TAG_W = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic [1:0]       cmd,
  input logic [1:0]       cfg_bl,
  input logic             rise_vld,
  input logic [TAG_W-1:0] rise_tag,
  input logic [2:0]       rise_idx,
  input logic             fall_vld,
  input logic [TAG_W-1:0] fall_tag,
  input logic [2:0]       fall_idx,
  input logic             proto_err
);

  logic [1:0] since_rst;
  logic [2:0] m;

  assign m = (cfg_bl == 2'd0) ? 3'd1 : (cfg_bl == 2'd1) ? 3'd3 : 3'd7;

  always_ff @(posedge clk) begin
    if (!rst_n) since_rst <= 2'd0;
    else if (since_rst != 2'd3) since_rst <= since_rst + 2'd1;
  end

  AST_IDLE_AFTER_RESET: assert property (@(posedge clk) disable iff (!rst_n)
    (since_rst != 2'd3) |-> (!rise_vld && !fall_vld)); // R1

  AST_IDX_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    (rise_vld && fall_vld && rise_tag == fall_tag) |->
      (fall_idx == ((rise_idx & ~m) | (3'(rise_idx + 3'd1) & m)))); // R5

  AST_TAG_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (rise_vld && fall_vld && rise_tag != fall_tag) |->
      (fall_tag == TAG_W'(rise_tag + 1'b1))); // R6

  AST_RESERVED_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd == 2'd3) |=> proto_err); // R10

  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    proto_err |=> proto_err); // R11

endmodule

bind ddr_rd_trunc_tracker ddr_rd_trunc_tracker_chk #(.TAG_W(TAG_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .cmd(cmd), .cfg_bl(cfg_bl),
  .rise_vld(rise_vld), .rise_tag(rise_tag), .rise_idx(rise_idx),
  .fall_vld(fall_vld), .fall_tag(fall_tag), .fall_idx(fall_idx),
  .proto_err(proto_err)
);

// File: tb/sim_ddr_rd_trunc_tracker.sv
`timescale 1ns/1ps
module sim_ddr_rd_trunc_tracker;
  localparam int TAG_W = 4;
  localparam int HS    = 4096;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [1:0] cmd = 2'd0, bank = 2'd0, cfg_bl = 2'd2;
  logic [2:0] rd_col = 3'd0;
  logic cfg_cl_half = 1'b0;
  logic rise_vld, fall_vld, proto_err;
  logic [TAG_W-1:0] rise_tag, fall_tag;
  logic [2:0] rise_idx, fall_idx;

  always #2.5 clk = ~clk;

  ddr_rd_trunc_tracker #(.TAG_W(TAG_W)) u0 (
    .clk(clk), .rst_n(rst_n), .cmd(cmd), .bank(bank), .rd_col(rd_col),
    .cfg_bl(cfg_bl), .cfg_cl_half(cfg_cl_half),
    .rise_vld(rise_vld), .rise_tag(rise_tag), .rise_idx(rise_idx),
    .fall_vld(fall_vld), .fall_tag(fall_tag), .fall_idx(fall_idx),
    .proto_err(proto_err));

  int compared = 0, mismatched = 0;
  bit done = 0;
  bit ev [HS];
  int et [HS];
  int ei [HS];
  int edge_i, last_bank, tagn;
  bit exp_err;
  string ctx;

  function automatic int bl_of(input logic [1:0] s);
    return (s == 2'd0) ? 2 : (s == 2'd1) ? 4 : 8;
  endfunction

  function automatic int idx_of(input int c, input int n, input int bl);
    int m = bl - 1;
    return (c & 7 & ~m) | ((c + n) & m);
  endfunction

  task automatic chk(input string req, input string what, input int act, input int exp);
    compared++;
    if (act != exp) begin
      mismatched++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic clear_from(input int h);
    for (int j = h; j < HS; j++) ev[j] = 1'b0;
  endtask

  task automatic step(input logic [1:0] c, input logic [1:0] b, input int colv);
    int cc = edge_i;
    int h0 = 2 * cc + 4 + int'(cfg_cl_half);
    int bl = bl_of(cfg_bl);
    cmd = c; bank = b; rd_col = colv[2:0];
    if (c == 2'd1) begin
      clear_from(h0);
      for (int n = 0; n < bl; n++) begin
        ev[h0+n] = 1'b1; et[h0+n] = tagn; ei[h0+n] = idx_of(colv, n, bl);
      end
      tagn = (tagn + 1) % 16;
      last_bank = int'(b);
    end else if (c == 2'd2 && int'(b) == last_bank) begin
      clear_from(h0);
    end else if (c == 2'd3) begin
      exp_err = 1'b1;
    end
    @(negedge clk);
    chk(ctx, "rise valid", int'(rise_vld), int'(ev[2*cc]));
    if (ev[2*cc]) begin
      chk(ctx, "rise tag", int'(rise_tag), et[2*cc]);
      chk(ctx, "rise idx", int'(rise_idx), ei[2*cc]);
    end
    chk(ctx, "fall valid", int'(fall_vld), int'(ev[2*cc+1]));
    if (ev[2*cc+1]) begin
      chk(ctx, "fall tag", int'(fall_tag), et[2*cc+1]);
      chk(ctx, "fall idx", int'(fall_idx), ei[2*cc+1]);
    end
    chk("R10 R11", "error flag", int'(proto_err), int'(exp_err));
    edge_i++;
  endtask

  task automatic nops(input int k);
    for (int i = 0; i < k; i++) step(2'd0, 2'd0, 0);
  endtask

  task automatic phase(input logic [1:0] bls, input logic clh);
    @(negedge clk);
    rst_n = 1'b0; cmd = 2'd0; cfg_bl = bls; cfg_cl_half = clh;
    repeat (3) @(negedge clk);
    chk("R1", "reset rise valid", int'(rise_vld), 0);
    chk("R1", "reset fall valid", int'(fall_vld), 0);
    chk("R1", "reset error flag", int'(proto_err), 0);
    for (int j = 0; j < HS; j++) ev[j] = 1'b0;
    edge_i = 0; last_bank = -1; tagn = 0; exp_err = 1'b0;
    rst_n = 1'b1;
    ctx = "R1"; nops(3);
    ctx = "R4 R5"; step(2'd1, 2'd0, 5); nops(10);
    ctx = "R7"; step(2'd1, 2'd1, 2); nops(1); step(2'd1, 2'd2, 7);
    step(2'd1, 2'd0, 3); nops(10);
    ctx = "R9"; step(2'd1, 2'd1, 6); nops(1); step(2'd2, 2'd2, 0);
    step(2'd2, 2'd0, 0); nops(10); step(2'd2, 2'd1, 0); nops(3);
    ctx = "R8"; step(2'd1, 2'd3, 0); step(2'd2, 2'd3, 0); nops(8);
    step(2'd1, 2'd3, 4); nops(2); step(2'd2, 2'd3, 0); nops(8);
    ctx = "R10 R11"; step(2'd3, 2'd0, 0); step(2'd1, 2'd0, 1);
    step(2'd3, 2'd0, 0); nops(10);
    ctx = clh ? "R3 R6" : "R2 R6";
    for (int i = 0; i < 600; i++) begin
      int r = int'($urandom % 20);
      logic [1:0] c = (r < 10) ? 2'd0 : (r < 15) ? 2'd1 : (r < 19) ? 2'd2 : 2'd3;
      step(c, 2'($urandom), int'($urandom % 8));
    end
    nops(10);
  endtask

  initial begin
    int seed_v;
    seed_v = $urandom(32'd20517);
    for (int b = 0; b < 4; b++)
      for (int h = 0; h < 2; h++)
        phase(2'(b), 1'(h));
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    #(200000 * 5);
    if (!done) begin
      compared++; mismatched++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end
endmodule